// File: doc/BRIEF.md
# Shift and Rotate Execution Unit

This block is a 32-bit execution unit for single-operand shifts and rotates. It handles seven operations on one operand:

- plain rotate left and right;
- rotate left and right through the carry flag, where carry acts as a 33rd bit;
- logical shift left and right;
- arithmetic shift right.

The shift amount comes from one of three sources: a fixed amount of one, an 8-bit immediate, or the low byte of a count register. Only the low five bits of the immediate or the register take effect.

For each operation the unit returns the shifted result and a write-back enable. It also returns new values for the carry, overflow, sign, zero and parity flags, each with its own update enable. Rotates touch only carry and overflow. Overflow is defined only for a shift amount of one. An effective amount of zero changes nothing.

Operations enter on a valid/ready input and leave on a valid/ready output, with one register stage between them. The upstream side may present an operation only by holding `in_valid` with stable inputs until `in_ready` is seen high at a rising edge. The unit raises `in_ready` whenever its output register is empty or is being drained in the same cycle (`out_ready` high). While `out_valid` is high and `out_ready` is low, every output holds its value and no new operation is accepted.

Top module: `shrot_unit`

## Requirements
- R1: The effective amount n depends on `form_i`. With `form_i`=0, n is 1. With `form_i`=1, n is `imm_i[4:0]`. With `form_i`=2 or 3, n is `creg_i[4:0]`. Bits 7:5 of the chosen byte have no effect.
- R2: When n is 0, the output carries `wr_en_o`=0, all five flag enables at 0, and `res_o` equal to the operand.
- R3: Operation codes are 0 for rotate left and 1 for rotate right. The result is the operand rotated by n. Carry becomes result bit 0 after rotate left and result bit 31 after rotate right.
- R4: Operation codes are 2 for rotate left through carry and 3 for rotate right through carry. These rotate the 33-bit value {carry, operand} by n.
  - Left: the old carry lands at result bit n-1, and new carry is operand bit 32-n.
  - Right: the old carry lands at result bit 32-n, and new carry is operand bit n-1.
- R5: Operation codes are 4 for logical shift left and 5 for logical shift right. Vacated bits are zero. Carry is operand bit 32-n for the left shift and operand bit n-1 for the right shift.
- R6: Operation code 6 is arithmetic shift right. It fills vacated upper bits with operand bit 31, and carry is operand bit n-1.
- R7: The overflow enable is high only when n is 1 and the operation writes. The overflow value depends on the operation:
  - rotates: result bit 31 XOR operand bit 31;
  - shift left: result bit 31 XOR new carry;
  - logical shift right: operand bit 31;
  - arithmetic shift right: 0.
- R8: For codes 4 to 6 with n nonzero, the sign, zero and parity enables are high. Sign is result bit 31. Zero is 1 when the result is 0. Parity is 1 when result bits 7:0 hold an even number of ones. For rotates these three enables stay low.
- R9: An accepted operation appears on the output on the next rising edge. A stalled output holds stable and blocks further input. No operation is dropped or duplicated.
- R10: Operation code 7 produces `wr_en_o`=0, no flag enables, and `res_o` equal to the operand.
- R11: After reset, `out_valid` is 0 and `in_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operation present |
| in_ready | output | 1 | Unit can take an operation |
| op_i | input | 3 | Operation code |
| a_i | input | 32 | Operand |
| cin_i | input | 1 | Incoming carry flag |
| form_i | input | 2 | Amount source select |
| imm_i | input | 8 | Immediate amount byte |
| creg_i | input | 8 | Count register low byte |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Downstream takes the result |
| res_o | output | 32 | Result |
| wr_en_o | output | 1 | Write-back enable |
| cf_o | output | 1 | New carry |
| of_o | output | 1 | New overflow |
| sf_o | output | 1 | New sign |
| zf_o | output | 1 | New zero |
| pf_o | output | 1 | New parity |
| cf_we_o | output | 1 | Carry update enable |
| of_we_o | output | 1 | Overflow update enable |
| sf_we_o | output | 1 | Sign update enable |
| zf_we_o | output | 1 | Zero update enable |
| pf_we_o | output | 1 | Parity update enable |

## Verification
Two functions can fall in the same cycle. In that cycle the output register hands over a finished result, and the input side accepts the next operation into the same register. Holding that register under back-pressure is the second function that must coexist with acceptance. The bench drives `out_ready` from a pseudo-random pattern while operations stream in back to back. This produces drain-and-refill cycles as well as multi-cycle stalls. A scoreboard queue filled at acceptance and emptied at each output transfer exposes any result that is lost, repeated or changed while stalled.

// File: rtl/shrot_pkg.sv
package shrot_pkg;
  typedef enum logic [2:0] {
    OP_ROL = 3'd0,
    OP_ROR = 3'd1,
    OP_RCL = 3'd2,
    OP_RCR = 3'd3,
    OP_SHL = 3'd4,
    OP_SHR = 3'd5,
    OP_SAR = 3'd6,
    OP_NOP = 3'd7
  } shrot_op_e;

  typedef struct packed {
    logic cf;
    logic of;
    logic sf;
    logic zf;
    logic pf;
  } flag_s;
endpackage

// File: rtl/shrot_count.sv
module shrot_count #(
  parameter int IMM_W = 8,
  parameter int CW    = 5
) (
  input  logic [1:0]       form_i,
  input  logic [IMM_W-1:0] imm_i,
  input  logic [IMM_W-1:0] creg_i,
  output logic [CW-1:0]    cnt_o,
  output logic             zero_o
);
  always_comb begin
    unique case (form_i)
      2'd0:    cnt_o = CW'(1);
      2'd1:    cnt_o = imm_i[CW-1:0];
      default: cnt_o = creg_i[CW-1:0];
    endcase
    zero_o = (cnt_o == '0);
  end
endmodule

// File: rtl/shrot_core.sv
module shrot_core
  import shrot_pkg::*;
#(
  parameter int W  = 32,
  parameter int CW = 5
) (
  input  shrot_op_e       op_i,
  input  logic [W-1:0]    a_i,
  input  logic            cin_i,
  input  logic [CW-1:0]   n_i,
  output logic [W-1:0]    res_o,
  output logic            cout_o,
  output logic            ovf_o
);
  logic [2*W-1:0] dbl_l;
  logic [2*W-1:0] dbl_r;
  logic [2*W+1:0] ring_l;
  logic [2*W+1:0] ring_r;
  logic [W:0]     shl_t;
  logic [W:0]     shr_t;
  logic [W:0]     sar_t;

  always_comb begin
    dbl_l  = {a_i, a_i} << n_i;
    dbl_r  = {a_i, a_i} >> n_i;
    ring_l = {cin_i, a_i, cin_i, a_i} << n_i;
    ring_r = {cin_i, a_i, cin_i, a_i} >> n_i;
    shl_t  = {1'b0, a_i} << n_i;
    shr_t  = {a_i, 1'b0} >> n_i;
    sar_t  = $signed({a_i, 1'b0}) >>> n_i;

    res_o  = a_i;
    cout_o = cin_i;
    unique case (op_i)
      OP_ROL: begin res_o = dbl_l[2*W-1:W];   cout_o = dbl_l[W];     end
      OP_ROR: begin res_o = dbl_r[W-1:0];     cout_o = dbl_r[W-1];   end
      OP_RCL: begin res_o = ring_l[2*W:W+1];  cout_o = ring_l[2*W+1]; end
      OP_RCR: begin res_o = ring_r[W-1:0];    cout_o = ring_r[W];    end
      OP_SHL: begin res_o = shl_t[W-1:0];     cout_o = shl_t[W];     end
      OP_SHR: begin res_o = shr_t[W:1];       cout_o = shr_t[0];     end
      OP_SAR: begin res_o = sar_t[W:1];       cout_o = sar_t[0];     end
      default: ;
    endcase

    unique case (op_i)
      OP_SHL:  ovf_o = res_o[W-1] ^ cout_o;
      OP_SHR:  ovf_o = a_i[W-1];
      OP_SAR:  ovf_o = 1'b0;
      default: ovf_o = res_o[W-1] ^ a_i[W-1];
    endcase
  end
endmodule

// File: rtl/shrot_flags.sv
module shrot_flags
  import shrot_pkg::*;
#(
  parameter int W  = 32,
  parameter int CW = 5
) (
  input  shrot_op_e     op_i,
  input  logic [W-1:0]  res_i,
  input  logic [CW-1:0] n_i,
  input  logic          n_zero_i,
  output logic          wr_o,
  output flag_s         we_o,
  output logic          sf_o,
  output logic          zf_o,
  output logic          pf_o
);
  logic is_shift;

  always_comb begin
    is_shift = (op_i == OP_SHL) || (op_i == OP_SHR) || (op_i == OP_SAR);
    wr_o     = (op_i != OP_NOP) && !n_zero_i;
    we_o.cf  = wr_o;
    we_o.of  = wr_o && (n_i == CW'(1));
    we_o.sf  = wr_o && is_shift;
    we_o.zf  = wr_o && is_shift;
    we_o.pf  = wr_o && is_shift;
    sf_o     = res_i[W-1];
    zf_o     = (res_i == '0);
    pf_o     = ~^res_i[7:0];
  end
endmodule

// File: rtl/shrot_unit.sv
module shrot_unit
  import shrot_pkg::*;
#(
  parameter int W     = 32,
  parameter int IMM_W = 8,
  localparam int CW   = $clog2(W)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [2:0]       op_i,
  input  logic [W-1:0]     a_i,
  input  logic             cin_i,
  input  logic [1:0]       form_i,
  input  logic [IMM_W-1:0] imm_i,
  input  logic [IMM_W-1:0] creg_i,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [W-1:0]     res_o,
  output logic             wr_en_o,
  output logic             cf_o,
  output logic             of_o,
  output logic             sf_o,
  output logic             zf_o,
  output logic             pf_o,
  output logic             cf_we_o,
  output logic             of_we_o,
  output logic             sf_we_o,
  output logic             zf_we_o,
  output logic             pf_we_o
);
  shrot_op_e     op;
  logic [CW-1:0] n;
  logic          n_zero;
  logic [W-1:0]  core_res;
  logic          core_cf;
  logic          core_of;
  logic          wr;
  flag_s         we;
  logic          f_sf;
  logic          f_zf;
  logic          f_pf;

  assign op = shrot_op_e'(op_i);

  shrot_count #(.IMM_W(IMM_W), .CW(CW)) u_cnt (
    .form_i (form_i),
    .imm_i  (imm_i),
    .creg_i (creg_i),
    .cnt_o  (n),
    .zero_o (n_zero)
  );

  shrot_core #(.W(W), .CW(CW)) u_core (
    .op_i   (op),
    .a_i    (a_i),
    .cin_i  (cin_i),
    .n_i    (n),
    .res_o  (core_res),
    .cout_o (core_cf),
    .ovf_o  (core_of)
  );

  shrot_flags #(.W(W), .CW(CW)) u_flg (
    .op_i     (op),
    .res_i    (core_res),
    .n_i      (n),
    .n_zero_i (n_zero),
    .wr_o     (wr),
    .we_o     (we),
    .sf_o     (f_sf),
    .zf_o     (f_zf),
    .pf_o     (f_pf)
  );

  assign in_ready = !out_valid || out_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      res_o     <= '0;
      wr_en_o   <= 1'b0;
      cf_o      <= 1'b0;
      of_o      <= 1'b0;
      sf_o      <= 1'b0;
      zf_o      <= 1'b0;
      pf_o      <= 1'b0;
      cf_we_o   <= 1'b0;
      of_we_o   <= 1'b0;
      sf_we_o   <= 1'b0;
      zf_we_o   <= 1'b0;
      pf_we_o   <= 1'b0;
    end else if (in_ready) begin
      out_valid <= in_valid;
      if (in_valid) begin
        res_o   <= wr ? core_res : a_i;
        wr_en_o <= wr;
        cf_o    <= core_cf;
        of_o    <= core_of;
        sf_o    <= f_sf;
        zf_o    <= f_zf;
        pf_o    <= f_pf;
        cf_we_o <= we.cf;
        of_we_o <= we.of;
        sf_we_o <= we.sf;
        zf_we_o <= we.zf;
        pf_we_o <= we.pf;
      end
    end
  end
endmodule

// File: rtl/shrot_unit_chk.sv
module shrot_unit_chk #(
  parameter int W = 32
) (
  input logic         clk,
  input logic         rst_n,
  input logic         in_valid,
  input logic         in_ready,
  input logic         out_valid,
  input logic         out_ready,
  input logic [W-1:0] res_o,
  input logic         wr_en_o,
  input logic         zf_o,
  input logic         cf_we_o,
  input logic         of_we_o,
  input logic         sf_we_o,
  input logic         zf_we_o,
  input logic         pf_we_o
);
  AST_ACCEPT_FILLS: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> out_valid); // R9
  AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(res_o) && $stable(wr_en_o)); // R9
  AST_QUIET_NO_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !wr_en_o |-> !(cf_we_o || of_we_o || sf_we_o || zf_we_o || pf_we_o)); // R2
  AST_OVF_WITH_CARRY: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && of_we_o |-> cf_we_o && wr_en_o); // R7
  AST_SZP_TOGETHER: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (sf_we_o == zf_we_o) && (zf_we_o == pf_we_o)); // R8
  AST_ZERO_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && zf_we_o |-> (zf_o == (res_o == '0))); // R8
endmodule

bind shrot_unit shrot_unit_chk #(.W(W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .res_o     (res_o),
  .wr_en_o   (wr_en_o),
  .zf_o      (zf_o),
  .cf_we_o   (cf_we_o),
  .of_we_o   (of_we_o),
  .sf_we_o   (sf_we_o),
  .zf_we_o   (zf_we_o),
  .pf_we_o   (pf_we_o)
);

// File: tb/sim_shrot_unit.sv
`timescale 1ns/1ps
module sim_shrot_unit;
  typedef struct {
    logic [31:0] res;
    logic        wr, cf, of, sf, zf, pf;
    logic        cwe, owe, swe, zwe, pwe;
    int          tag;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [2:0]  op_i = '0;
  logic [31:0] a_i = '0;
  logic        cin_i = 1'b0;
  logic [1:0]  form_i = '0;
  logic [7:0]  imm_i = '0;
  logic [7:0]  creg_i = '0;
  logic        out_valid;
  logic        out_ready = 1'b0;
  logic [31:0] res_o;
  logic        wr_en_o, cf_o, of_o, sf_o, zf_o, pf_o;
  logic        cf_we_o, of_we_o, sf_we_o, zf_we_o, pf_we_o;

  int   n_chk = 0;
  int   n_bad = 0;
  exp_t sb[$];
  logic [15:0] lfsr = 16'hACE1;

  always #2.5 clk = ~clk;

  shrot_unit u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .op_i(op_i), .a_i(a_i), .cin_i(cin_i), .form_i(form_i), .imm_i(imm_i),
    .creg_i(creg_i), .out_valid(out_valid), .out_ready(out_ready),
    .res_o(res_o), .wr_en_o(wr_en_o), .cf_o(cf_o), .of_o(of_o), .sf_o(sf_o),
    .zf_o(zf_o), .pf_o(pf_o), .cf_we_o(cf_we_o), .of_we_o(of_we_o),
    .sf_we_o(sf_we_o), .zf_we_o(zf_we_o), .pf_we_o(pf_we_o)
  );

  function automatic string tag_name(int t);
    case (t)
      2: return "R2";  3: return "R3";  4: return "R4";
      5: return "R5";  6: return "R6";  default: return "R10";
    endcase
  endfunction

  // behavioural model built from the requirement text
  function automatic exp_t model(int op, logic [31:0] a, logic c, int form,
                                 logic [7:0] imm, logic [7:0] creg);
    exp_t e;
    int n;
    logic [32:0] x, y;
    n = (form == 0) ? 1 : (form == 1) ? int'(imm[4:0]) : int'(creg[4:0]); // R1
    e.res = a; e.wr = 0; e.cf = 0; e.of = 0; e.sf = 0; e.zf = 0; e.pf = 0;
    e.cwe = 0; e.owe = 0; e.swe = 0; e.zwe = 0; e.pwe = 0;
    e.tag = (op == 7) ? 10 : (n == 0) ? 2 : (op < 2) ? 3 : (op < 4) ? 4 : (op < 6) ? 5 : 6;
    if (op == 7 || n == 0) return e;
    x = {c, a};
    y = '0;
    for (int i = 0; i < 32; i++) begin
      case (op)
        0: e.res[(i + n) % 32] = a[i];
        1: e.res[i] = a[(i + n) % 32];
        4: e.res[i] = (i >= n) ? a[i - n] : 1'b0;
        5: e.res[i] = (i + n < 32) ? a[i + n] : 1'b0;
        6: e.res[i] = (i + n < 32) ? a[i + n] : a[31];
        default: ;
      endcase
    end
    for (int i = 0; i < 33; i++) begin
      if (op == 2) y[(i + n) % 33] = x[i];
      if (op == 3) y[i] = x[(i + n) % 33];
    end
    if (op == 2 || op == 3) e.res = y[31:0];
    case (op)
      0: e.cf = e.res[0];
      1: e.cf = e.res[31];
      2, 3: e.cf = y[32];
      4: e.cf = a[32 - n];
      default: e.cf = a[n - 1];
    endcase
    // R7 overflow rules
    case (op)
      4: e.of = e.res[31] ^ e.cf;
      5: e.of = a[31];
      6: e.of = 1'b0;
      default: e.of = e.res[31] ^ a[31];
    endcase
    e.wr = 1; e.cwe = 1; e.owe = (n == 1);
    if (op >= 4) begin // R8 sign, zero, parity
      e.swe = 1; e.zwe = 1; e.pwe = 1;
      e.sf = e.res[31]; e.zf = (e.res == 0); e.pf = ~^e.res[7:0];
    end
    return e;
  endfunction

  task automatic drive(int op, logic [31:0] a, logic c, int form,
                       logic [7:0] imm, logic [7:0] creg);
    @(negedge clk);
    op_i = 3'(op); a_i = a; cin_i = c; form_i = 2'(form); imm_i = imm; creg_i = creg;
    in_valid = 1'b1;
    #1;
    while (!in_ready) begin
      @(negedge clk);
      #1;
    end
    sb.push_back(model(op, a, c, form, imm, creg));
    @(posedge clk);
  endtask

  // monitor: pops an expected item for every output transfer (R9 ordering)
  initial begin
    forever begin
      @(negedge clk);
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      out_ready = lfsr[0] | lfsr[3];
      #2;
      if (rst_n && out_valid && out_ready) begin
        exp_t e;
        n_chk++;
        if (sb.size() == 0) begin
          n_bad++;
          $display("FAIL R9 unexpected output: actual res=%h expected none", res_o);
        end else begin
          e = sb.pop_front();
          if (res_o !== e.res || wr_en_o !== e.wr ||
              {cf_we_o, of_we_o, sf_we_o, zf_we_o, pf_we_o} !== {e.cwe, e.owe, e.swe, e.zwe, e.pwe} ||
              (e.cwe && cf_o !== e.cf) || (e.owe && of_o !== e.of) ||
              (e.swe && sf_o !== e.sf) || (e.zwe && zf_o !== e.zf) ||
              (e.pwe && pf_o !== e.pf)) begin
            n_bad++;
            $display("FAIL %s: actual res=%h wr=%b we=%b%b%b%b%b f=%b%b%b%b%b expected res=%h wr=%b we=%b%b%b%b%b f=%b%b%b%b%b",
              tag_name(e.tag), res_o, wr_en_o, cf_we_o, of_we_o, sf_we_o, zf_we_o, pf_we_o,
              cf_o, of_o, sf_o, zf_o, pf_o, e.res, e.wr, e.cwe, e.owe, e.swe, e.zwe, e.pwe,
              e.cf, e.of, e.sf, e.zf, e.pf);
          end
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] ops_a[4];
    ops_a[0] = 32'h8000_0001; ops_a[1] = 32'h5A3C_96E1;
    ops_a[2] = 32'hFFFF_FFFF; ops_a[3] = 32'h7F00_00FE;
    repeat (3) @(posedge clk);
    @(negedge clk);
    n_chk++; // R11 reset state
    if (out_valid !== 1'b0 || in_ready !== 1'b1) begin
      n_bad++;
      $display("FAIL R11: actual out_valid=%b in_ready=%b expected 0 1", out_valid, in_ready);
    end
    rst_n = 1'b1;
    // sweep: every op, every count, both carries; count source rotates (R1)
    for (int k = 0; k < 4; k++)
      for (int op = 0; op < 8; op++)
        for (int c = 0; c < 32; c++)
          for (int ci = 0; ci < 2; ci++) begin
            int form;
            logic [7:0] hi;
            hi = 8'(((k * 3 + c + op) % 8) << 5); // R1 upper bits must not matter
            form = (c == 1 && ci == 0) ? 0 : 1 + ((c + ci + k) % 3);
            drive(op, ops_a[k] ^ 32'(c * 32'h0101_0101), ci[0], form,
                  hi | 8'(c), hi | 8'(c));
          end
    // R1: constant-one form ignores both count bytes
    drive(4, 32'hC000_0000, 1'b0, 0, 8'h00, 8'h1F);
    // R2: upper-bit-only amount gives zero count
    drive(6, 32'h8000_0000, 1'b1, 1, 8'hE0, 8'h05);
    // R10: code 7 with a nonzero count
    drive(7, 32'h1234_5678, 1'b1, 2, 8'h00, 8'h03);
    @(negedge clk);
    in_valid = 1'b0;
    while (sb.size() != 0) @(negedge clk);
    repeat (2) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule